// File: doc/BRIEF.md
# Controller Enable and Ready Sequencer

This block owns the controller's enable bit and derives the ready status from it. Software flips enable to bring the controller up or take it down; ready follows only after the internal engines report that the work is finished. When enable rises, a one-cycle start pulse goes to the queue initialisation engine. Ready rises once that engine reports done. When enable falls, a one-cycle queue-reset pulse goes to the teardown engine. Ready stays high until teardown is done and every in-flight completion write has drained.

The block also holds the admin queue attribute register and the two admin queue base address registers. These can only be written while enable is clear. A controller reset leaves them untouched; only the block reset clears them.

An enable write that raises enable while ready is still 1, or lowers it while ready is still 0, is undefined. Such a write is dropped, and it raises a one-cycle error flag. Command fetch is permitted only while enable is set and the controller is ready.

Top module: `enable_ready_seq`

## Requirements
- R1: `fetchEn` is 1 only while `enable` is 1 and `ready` is 1. It drops in the cycle that `enable` reads back 0.
- R2: An accepted 1→0 enable write makes `queueRst` high for exactly one cycle. This is the second cycle after the write's clock edge. `ready` is still 1 in that cycle.
- R3: A controller reset (enable falling, teardown, ready falling) leaves the admin queue registers unchanged.
- R4: In teardown, `ready` falls at the edge where `teardownDone` and `drainIdle` are both sampled 1, and at no other time.
- R5: An accepted 0→1 enable write makes `initStart` high for exactly one cycle, in the second cycle after the write edge. `ready` rises at the edge where `initDone` is sampled 1 during bring-up.
- R6: An enable write of 1 while `enable`=0 and `ready`=1 is dropped. So is a write of 0 while `enable`=1 and `ready`=0. In either case `badEdge` is 1 for the single cycle after the write edge, and `enable` keeps its value.
- R7: An admin queue write takes effect only when `enable` reads 0. `aqWrSel` selects the target: 0 = attributes (low ATTR_W bits of the data), 1 = submission base, 2 = completion base, 3 = no register. A write while `enable` is 1 changes no register.
- R8: While `drainIdle` is 0, `ready` stays 1 through teardown, even if `teardownDone` is 1.
- R9: After block reset, `enable`, `ready`, `fetchEn`, `initStart`, `queueRst`, `badEdge` and all admin queue registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset |
| enWrStb | input | 1 | Enable bit write strobe |
| enWrVal | input | 1 | Value written to the enable bit |
| aqWrStb | input | 1 | Admin queue register write strobe |
| aqWrSel | input | 2 | Admin queue register select |
| aqWrData | input | AQ_DATA_W | Admin queue write data |
| initDone | input | 1 | Initialisation engine finished |
| teardownDone | input | 1 | Teardown engine finished |
| drainIdle | input | 1 | No completion write in flight |
| enable | output | 1 | Enable bit readback |
| ready | output | 1 | Ready status |
| fetchEn | output | 1 | Command fetch permitted |
| initStart | output | 1 | Start pulse to initialisation engine |
| queueRst | output | 1 | Queue reset pulse to teardown engine |
| badEdge | output | 1 | Undefined enable edge detected |
| aqAttr | output | ATTR_W | Admin queue attributes |
| aqSubBase | output | AQ_DATA_W | Admin submission queue base |
| aqCompBase | output | AQ_DATA_W | Admin completion queue base |

## Verification
Admin queue writes are tried with each select code while the controller is disabled. This checks the field routing, and shows that the unused code touches nothing. The same writes are then repeated while enabled, which separates the lock from the routing.

The enable sequence is driven through a full bring-up and teardown. An illegal edge is injected in each of the two transient phases, which shows that the error path leaves the state machine where it was. Finally, teardown is held with `teardownDone` high but `drainIdle` low. This tells the drain condition apart from the engine's done signal.

// File: rtl/enrdy_pkg.sv
package enrdy_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_BRINGUP = 2'd1,
    ST_LIVE    = 2'd2,
    ST_DRAIN   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic rdy;
    logic initGo;
    logic qRst;
  } seqStrobes_t;

  localparam logic [1:0] SEL_ATTR = 2'd0;
  localparam logic [1:0] SEL_SUB  = 2'd1;
  localparam logic [1:0] SEL_COMP = 2'd2;
endpackage

// File: rtl/enrdy_ctrl.sv
module enrdy_ctrl
  import enrdy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enBit,
  input  logic        initDone,
  input  logic        teardownDone,
  input  logic        drainIdle,
  output seqStrobes_t strobes
);
  seqState_t state, stateNxt;
  logic initGoQ, qRstQ;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_OFF:     if (enBit) stateNxt = ST_BRINGUP;
      ST_BRINGUP: if (initDone) stateNxt = ST_LIVE;
      ST_LIVE:    if (!enBit) stateNxt = ST_DRAIN;
      ST_DRAIN:   if (teardownDone && drainIdle) stateNxt = ST_OFF;
      default:    stateNxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      initGoQ <= 1'b0;
      qRstQ   <= 1'b0;
    end else begin
      state   <= stateNxt;
      initGoQ <= (state == ST_OFF)  && (stateNxt == ST_BRINGUP);
      qRstQ   <= (state == ST_LIVE) && (stateNxt == ST_DRAIN);
    end
  end

  always_comb begin
    strobes.rdy    = (state == ST_LIVE) || (state == ST_DRAIN);
    strobes.initGo = initGoQ;
    strobes.qRst   = qRstQ;
  end
endmodule

// File: rtl/enrdy_dpath.sv
module enrdy_dpath
  import enrdy_pkg::*;
#(
  parameter int AQ_DATA_W = 64,
  parameter int ATTR_W    = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enWrStb,
  input  logic                 enWrVal,
  input  logic                 aqWrStb,
  input  logic [1:0]           aqWrSel,
  input  logic [AQ_DATA_W-1:0] aqWrData,
  input  seqStrobes_t          strobes,
  output logic                 enBit,
  output logic                 badEdge,
  output logic [ATTR_W-1:0]    aqAttr,
  output logic [AQ_DATA_W-1:0] aqSubBase,
  output logic [AQ_DATA_W-1:0] aqCompBase
);
  logic wantRise, wantFall, riseBad, fallBad, aqOpen;

  always_comb begin
    wantRise = enWrStb &&  enWrVal && !enBit;
    wantFall = enWrStb && !enWrVal &&  enBit;
    riseBad  = wantRise &&  strobes.rdy;
    fallBad  = wantFall && !strobes.rdy;
    aqOpen   = aqWrStb && !enBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      badEdge <= 1'b0;
    end else begin
      badEdge <= riseBad || fallBad;
      if (wantRise && !riseBad) enBit <= 1'b1;
      else if (wantFall && !fallBad) enBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aqAttr     <= '0;
      aqSubBase  <= '0;
      aqCompBase <= '0;
    end else if (aqOpen) begin
      case (aqWrSel)
        SEL_ATTR: aqAttr     <= aqWrData[ATTR_W-1:0];
        SEL_SUB:  aqSubBase  <= aqWrData;
        SEL_COMP: aqCompBase <= aqWrData;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/enable_ready_seq.sv
module enable_ready_seq
  import enrdy_pkg::*;
#(
  parameter int AQ_DATA_W = 64,
  parameter int ATTR_W    = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enWrStb,
  input  logic                 enWrVal,
  input  logic                 aqWrStb,
  input  logic [1:0]           aqWrSel,
  input  logic [AQ_DATA_W-1:0] aqWrData,
  input  logic                 initDone,
  input  logic                 teardownDone,
  input  logic                 drainIdle,
  output logic                 enable,
  output logic                 ready,
  output logic                 fetchEn,
  output logic                 initStart,
  output logic                 queueRst,
  output logic                 badEdge,
  output logic [ATTR_W-1:0]    aqAttr,
  output logic [AQ_DATA_W-1:0] aqSubBase,
  output logic [AQ_DATA_W-1:0] aqCompBase
);
  seqStrobes_t strobes;
  logic enBit;

  enrdy_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .initDone(initDone),
    .teardownDone(teardownDone), .drainIdle(drainIdle), .strobes(strobes)
  );

  enrdy_dpath #(.AQ_DATA_W(AQ_DATA_W), .ATTR_W(ATTR_W)) uDpath (
    .clk(clk), .rstN(rstN), .enWrStb(enWrStb), .enWrVal(enWrVal),
    .aqWrStb(aqWrStb), .aqWrSel(aqWrSel), .aqWrData(aqWrData),
    .strobes(strobes), .enBit(enBit), .badEdge(badEdge),
    .aqAttr(aqAttr), .aqSubBase(aqSubBase), .aqCompBase(aqCompBase)
  );

  assign enable    = enBit;
  assign ready     = strobes.rdy;
  assign fetchEn   = strobes.rdy && enBit;
  assign initStart = strobes.initGo;
  assign queueRst  = strobes.qRst;
endmodule

// File: rtl/enable_ready_seq_chk.sv
module enable_ready_seq_chk #(
  parameter int AQ_DATA_W = 64,
  parameter int ATTR_W    = 28
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enWrStb,
  input logic                 enWrVal,
  input logic                 aqWrStb,
  input logic                 initDone,
  input logic                 teardownDone,
  input logic                 drainIdle,
  input logic                 enable,
  input logic                 ready,
  input logic                 fetchEn,
  input logic                 queueRst,
  input logic                 badEdge,
  input logic [ATTR_W-1:0]    aqAttr,
  input logic [AQ_DATA_W-1:0] aqSubBase,
  input logic [AQ_DATA_W-1:0] aqCompBase
);
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn |-> (enable && ready)); // R1

  AST_QRST_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |=> (queueRst && ready)); // R2

  AST_RDY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(teardownDone && drainIdle)); // R4

  AST_RDY_RISE_INIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(initDone) && enable)); // R5

  AST_BAD_RISE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (enWrStb && enWrVal && !enable && ready) |=> (!enable && badEdge)); // R6

  AST_BAD_FALL_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (enWrStb && !enWrVal && enable && !ready) |=> (enable && badEdge)); // R6

  AST_AQ_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (aqWrStb && enable) |=> ($stable(aqAttr) && $stable(aqSubBase) && $stable(aqCompBase))); // R7

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !enable && !drainIdle) |=> ready); // R8
endmodule

bind enable_ready_seq enable_ready_seq_chk #(.AQ_DATA_W(AQ_DATA_W), .ATTR_W(ATTR_W)) uChk (
  .clk(clk), .rstN(rstN), .enWrStb(enWrStb), .enWrVal(enWrVal), .aqWrStb(aqWrStb),
  .initDone(initDone), .teardownDone(teardownDone), .drainIdle(drainIdle),
  .enable(enable), .ready(ready), .fetchEn(fetchEn), .queueRst(queueRst),
  .badEdge(badEdge), .aqAttr(aqAttr), .aqSubBase(aqSubBase), .aqCompBase(aqCompBase)
);

// File: tb/tb_enable_ready_seq.sv
module tb_enable_ready_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int AW = 28;
  localparam int NVEC = 4;

  // sel, data, expected attr, sub base, comp base after the write
  localparam logic [1:0]    V_SEL  [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [DW-1:0] V_DATA [NVEC] = '{64'hFFFF_FFFF_F123_4567, 64'h0000_00AB_CDEF_1000,
                                              64'h0000_0012_3456_7000, 64'hDEAD_BEEF_DEAD_BEEF};
  localparam logic [AW-1:0] V_ATTR [NVEC] = '{28'h123_4567, 28'h123_4567, 28'h123_4567, 28'h123_4567};
  localparam logic [DW-1:0] V_SUB  [NVEC] = '{64'h0, 64'h0000_00AB_CDEF_1000,
                                              64'h0000_00AB_CDEF_1000, 64'h0000_00AB_CDEF_1000};
  localparam logic [DW-1:0] V_COMP [NVEC] = '{64'h0, 64'h0, 64'h0000_0012_3456_7000, 64'h0000_0012_3456_7000};

  logic clk = 1'b0, rstN = 1'b0;
  logic enWrStb = 0, enWrVal = 0, aqWrStb = 0;
  logic [1:0] aqWrSel = 0;
  logic [DW-1:0] aqWrData = '0;
  logic initDone = 0, teardownDone = 0, drainIdle = 0;
  logic enable, ready, fetchEn, initStart, queueRst, badEdge;
  logic [AW-1:0] aqAttr;
  logic [DW-1:0] aqSubBase, aqCompBase;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enable_ready_seq #(.AQ_DATA_W(DW), .ATTR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .enWrStb(enWrStb), .enWrVal(enWrVal),
    .aqWrStb(aqWrStb), .aqWrSel(aqWrSel), .aqWrData(aqWrData),
    .initDone(initDone), .teardownDone(teardownDone), .drainIdle(drainIdle),
    .enable(enable), .ready(ready), .fetchEn(fetchEn), .initStart(initStart),
    .queueRst(queueRst), .badEdge(badEdge), .aqAttr(aqAttr),
    .aqSubBase(aqSubBase), .aqCompBase(aqCompBase)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkAq(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] s,
                       input logic [DW-1:0] c);
    chk({tag, " attr"}, 64'(aqAttr), 64'(a));
    chk({tag, " sub"}, aqSubBase, s);
    chk({tag, " comp"}, aqCompBase, c);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R9 reset state
    chk("R9 enable", 64'(enable), 0);
    chk("R9 ready", 64'(ready), 0);
    chk("R9 fetchEn", 64'(fetchEn), 0);
    chk("R9 pulses", 64'({initStart, queueRst, badEdge}), 0);
    chkAq("R9", '0, '0, '0);
    rstN = 1'b1;
    step();

    // R7 table: admin queue writes while disabled
    for (int i = 0; i < NVEC; i++) begin
      aqWrStb = 1; aqWrSel = V_SEL[i]; aqWrData = V_DATA[i];
      step();
      aqWrStb = 0;
      chkAq("R7 table", V_ATTR[i], V_SUB[i], V_COMP[i]);
    end

    // bring-up
    enWrStb = 1; enWrVal = 1;
    step();
    enWrStb = 0;
    chk("R5 enable set", 64'(enable), 1);
    chk("R5 start not yet", 64'(initStart), 0);
    step();
    chk("R5 initStart", 64'(initStart), 1);
    chk("R5 ready low in init", 64'(ready), 0);
    // R6 illegal fall during bring-up
    enWrStb = 1; enWrVal = 0;
    step();
    enWrStb = 0;
    chk("R5 initStart one cycle", 64'(initStart), 0);
    chk("R6 bad fall flag", 64'(badEdge), 1);
    chk("R6 bad fall ignored", 64'(enable), 1);
    // R7 locked write
    aqWrStb = 1; aqWrSel = 2'd1; aqWrData = 64'h5555;
    step();
    aqWrStb = 0;
    chk("R6 flag one cycle", 64'(badEdge), 0);
    chkAq("R7 locked", V_ATTR[3], V_SUB[3], V_COMP[3]);
    initDone = 1;
    step();
    initDone = 0;
    chk("R5 ready rises", 64'(ready), 1);
    chk("R1 fetch on", 64'(fetchEn), 1);

    // teardown
    enWrStb = 1; enWrVal = 0;
    step();
    enWrStb = 0;
    chk("R1 fetch off", 64'(fetchEn), 0);
    chk("R2 ready still", 64'(ready), 1);
    chk("R2 no pulse yet", 64'(queueRst), 0);
    // R6 illegal rise while ready still 1
    enWrStb = 1; enWrVal = 1;
    step();
    enWrStb = 0;
    chk("R2 queueRst", 64'(queueRst), 1);
    chk("R6 bad rise flag", 64'(badEdge), 1);
    chk("R6 bad rise ignored", 64'(enable), 0);
    teardownDone = 1; drainIdle = 0;
    step();
    chk("R2 queueRst one cycle", 64'(queueRst), 0);
    step();
    chk("R8 held by drain", 64'(ready), 1);
    drainIdle = 1;
    step();
    teardownDone = 0;
    chk("R4 ready falls", 64'(ready), 0);
    chkAq("R3 retained", V_ATTR[3], V_SUB[3], V_COMP[3]);
    step();
    chk("R4 stays low", 64'(ready), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule